// File: doc/BRIEF.md
# Frame Slip Elastic Store

This block sits in a T1/J1 receive path between the recovered line timing and the system frame timing. Incoming frames are written one byte per write strobe. Each frame opens with a start marker. Frames are read out one byte per read strobe against the system's own frame starts. The two sides share one clock. Each side advances only on its own enable, so the write and read rates can differ freely. Storage holds two frame slots of `FRAME_BYTES` bytes each. The reader always owns one slot: the frame it is playing, which is also the frame it would replay. The writer fills the other slot.

When the rates drift apart, the block slips whole frames and never splits one. The reader may reach a frame start with no complete new frame waiting. It then plays its current frame again, which is a duplicate slip. The writer may reach a frame start with no free slot. The incoming frame is then thrown away, which is a delete slip. Both decisions use the occupancy at the start of the cycle. A sticky indication bit records that a slip happened. A direction bit records which kind the latest slip was. An interrupt line follows the indication when enabled.

A one-bit-address register port gives access to the block. Address 0 is a configuration register whose bit 0 enables the interrupt. Address 1 is a read-only status register: bit 0 is the slip indication and bit 1 the slip direction (1 = delete, 0 = duplicate). Reading status returns the value held before the read and clears the indication. The reset input is asynchronous, and its release is synchronised inside the block over two clock edges.

Top module: `frame_slip_store`

## Requirements
- R1: After reset, both register reads return 0 and `irq` is low.
- R2: A complete frame written before a read frame start is read out byte for byte in write order. `rd_data` shows each byte on the cycle after the `rd_en` that requested it.
- R3: If no complete new frame is waiting at a read frame start (`rd_en` with `rd_sof`), the frame last read is played again from its first byte. The indication is set and the direction becomes 0.
- R4: If a write frame start finds the one free slot already holding an unread frame, the whole incoming frame is discarded and the stored frame is delivered unchanged. The indication is set and the direction becomes 1.
- R5: A status read (`reg_rd` at address 1) returns {direction, indication} on `reg_rdata[1:0]` on the next cycle and clears the indication.
- R6: If a slip and a status read fall in the same cycle, the indication stays set.
- R7: `irq` is high exactly while the indication is set and configuration bit 0 is 1. Configuration bit 0 reads back at address 0, bit 0.
- R8: The direction bit holds the kind of the most recent slip, so a later slip of the other kind overwrites it.
- R9: After reset the reader owns one slot and the write slot is free, so one frame can be written and then read without any slip.
- R10: A write frame start that arrives before the current frame is complete abandons the partial frame. Write bytes without a start marker after a complete frame are ignored.
- R11: A register write to address 1 changes nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Single clock for both sides |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write byte strobe |
| wr_sof | input | 1 | Marks the first byte of a written frame |
| wr_data | input | 8 | Written byte |
| rd_en | input | 1 | Read byte strobe |
| rd_sof | input | 1 | Read frame start; the slip decision point on the read side |
| rd_data | output | 8 | Read byte, one cycle after `rd_en` |
| reg_addr | input | 1 | 0 = configuration, 1 = status |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_wdata | input | 1 | Write data (interrupt enable) |
| reg_rdata | output | 2 | Read data, one cycle after `reg_rd` |
| irq | output | 1 | Slip interrupt |

## Verification
A wrong slot pointer or occupancy count shows up at the read port within one frame. The reader either replays when it should advance, or advances into a slot that holds a stale or discarded frame, so whole-frame byte comparison exposes it at the next read frame start. A bad indication or direction register shows at `reg_rdata` on the first status read after the slip, and at `irq` one cycle after the slip edge. The same-cycle slip-and-read case is driven on purpose, because a wrong priority there loses the event silently.

// File: rtl/esb_pkg.sv
`timescale 1ns/1ps
package esb_pkg;
  typedef logic [7:0] byte_t;

  typedef enum logic {
    REG_CFG    = 1'b0,
    REG_STATUS = 1'b1
  } reg_sel_e;

  localparam int STAT_FLAG_BIT = 0;
  localparam int STAT_DIR_BIT  = 1;

  // (slot + step) modulo the slot count
  function automatic int slot_step(input int slot, input int step, input int n);
    return (slot + step) % n;
  endfunction
endpackage

// File: rtl/esb_occupancy.sv
`timescale 1ns/1ps
module esb_occupancy #(
  parameter int NUM_FRAMES = 2,
  localparam int SW = $clog2(NUM_FRAMES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          commit,
  input  logic          take,
  output logic [SW-1:0] fill,
  output logic [SW-1:0] rslot
);
  logic [SW-1:0] fill_n, rslot_n;

  always_comb begin
    fill_n  = fill;
    rslot_n = rslot;
    if (commit && !take) fill_n = fill + SW'(1);
    if (take && !commit) fill_n = fill - SW'(1);
    if (take) rslot_n = SW'(esb_pkg::slot_step(int'(rslot), 1, NUM_FRAMES));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fill  <= '0;
      rslot <= '0;
    end else begin
      fill  <= fill_n;
      rslot <= rslot_n;
    end
  end
endmodule

// File: rtl/esb_wr_ctrl.sv
`timescale 1ns/1ps
module esb_wr_ctrl #(
  parameter int FRAME_BYTES = 24,
  parameter int NUM_FRAMES  = 2,
  localparam int SW = $clog2(NUM_FRAMES),
  localparam int BW = $clog2(FRAME_BYTES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          wr_sof,
  input  logic [SW-1:0] fill,
  input  logic [SW-1:0] rslot,
  output logic          mem_we,
  output logic [SW-1:0] mem_wslot,
  output logic [BW-1:0] mem_wbyte,
  output logic          commit,
  output logic          del_slip
);
  localparam logic [SW-1:0] FILL_FULL = SW'(NUM_FRAMES - 1);
  localparam logic [BW-1:0] LAST_BYTE = BW'(FRAME_BYTES - 1);

  logic          wactive, wactive_n;
  logic [SW-1:0] wslot, wslot_n, target;
  logic [BW-1:0] wbyte, wbyte_n;

  assign target = SW'(esb_pkg::slot_step(int'(rslot), int'(fill) + 1, NUM_FRAMES));

  always_comb begin
    wactive_n = wactive;
    wslot_n   = wslot;
    wbyte_n   = wbyte;
    mem_we    = 1'b0;
    mem_wslot = wslot;
    mem_wbyte = wbyte;
    commit    = 1'b0;
    del_slip  = 1'b0;
    if (wr_en) begin
      if (wr_sof) begin
        if (fill == FILL_FULL) begin
          del_slip  = 1'b1;
          wactive_n = 1'b0;
        end else begin
          mem_we    = 1'b1;
          mem_wslot = target;
          mem_wbyte = '0;
          wslot_n   = target;
          wbyte_n   = BW'(1);
          wactive_n = 1'b1;
        end
      end else if (wactive) begin
        mem_we = 1'b1;
        if (wbyte == LAST_BYTE) begin
          commit    = 1'b1;
          wactive_n = 1'b0;
          wbyte_n   = '0;
        end else begin
          wbyte_n = wbyte + BW'(1);
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wactive <= 1'b0;
      wslot   <= '0;
      wbyte   <= '0;
    end else begin
      wactive <= wactive_n;
      wslot   <= wslot_n;
      wbyte   <= wbyte_n;
    end
  end
endmodule

// File: rtl/esb_rd_ctrl.sv
`timescale 1ns/1ps
module esb_rd_ctrl #(
  parameter int FRAME_BYTES = 24,
  parameter int NUM_FRAMES  = 2,
  localparam int SW = $clog2(NUM_FRAMES),
  localparam int BW = $clog2(FRAME_BYTES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_en,
  input  logic          rd_sof,
  input  logic [SW-1:0] fill,
  input  logic [SW-1:0] rslot,
  output logic          mem_re,
  output logic [SW-1:0] mem_rslot,
  output logic [BW-1:0] mem_rbyte,
  output logic          take,
  output logic          dup_slip
);
  localparam logic [BW-1:0] LAST_BYTE = BW'(FRAME_BYTES - 1);

  logic [BW-1:0] rbyte, rbyte_n;

  always_comb begin
    rbyte_n   = rbyte;
    mem_re    = 1'b0;
    mem_rslot = rslot;
    mem_rbyte = rbyte;
    take      = 1'b0;
    dup_slip  = 1'b0;
    if (rd_en) begin
      mem_re = 1'b1;
      if (rd_sof) begin
        mem_rbyte = '0;
        rbyte_n   = BW'(1);
        if (fill == '0) begin
          dup_slip = 1'b1;
        end else begin
          take      = 1'b1;
          mem_rslot = SW'(esb_pkg::slot_step(int'(rslot), 1, NUM_FRAMES));
        end
      end else begin
        rbyte_n = (rbyte == LAST_BYTE) ? '0 : rbyte + BW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rbyte <= '0;
    else        rbyte <= rbyte_n;
  end
endmodule

// File: rtl/esb_store.sv
`timescale 1ns/1ps
module esb_store #(
  parameter int FRAME_BYTES = 24,
  parameter int NUM_FRAMES  = 2,
  localparam int SW    = $clog2(NUM_FRAMES),
  localparam int BW    = $clog2(FRAME_BYTES),
  localparam int DEPTH = FRAME_BYTES * NUM_FRAMES,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [SW-1:0] wslot,
  input  logic [BW-1:0] wbyte,
  input  esb_pkg::byte_t wdata,
  input  logic          re,
  input  logic [SW-1:0] rslot,
  input  logic [BW-1:0] rbyte,
  output esb_pkg::byte_t rdata
);
  esb_pkg::byte_t mem [DEPTH];
  logic [AW-1:0]  waddr, raddr;

  assign waddr = AW'(int'(wslot) * FRAME_BYTES + int'(wbyte));
  assign raddr = AW'(int'(rslot) * FRAME_BYTES + int'(rbyte));

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  rdata <= '0;
    else if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/esb_status.sv
`timescale 1ns/1ps
module esb_status (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_addr,
  input  logic       reg_wr,
  input  logic       reg_rd,
  input  logic       reg_wdata,
  input  logic       del_slip,
  input  logic       dup_slip,
  output logic [1:0] reg_rdata,
  output logic       slip_flag,
  output logic       slip_dir,
  output logic       slip_ie,
  output logic       irq
);
  import esb_pkg::*;

  logic       flag_n, dir_n, ie_n;
  logic [1:0] rdata_n, status_word;

  always_comb begin
    status_word                = '0;
    status_word[STAT_FLAG_BIT] = slip_flag;
    status_word[STAT_DIR_BIT]  = slip_dir;
  end

  always_comb begin
    ie_n    = slip_ie;
    flag_n  = slip_flag;
    dir_n   = slip_dir;
    rdata_n = reg_rdata;
    if (reg_wr && reg_addr == REG_CFG) ie_n = reg_wdata;
    if (reg_rd) begin
      rdata_n = (reg_addr == REG_STATUS) ? status_word : {1'b0, slip_ie};
      if (reg_addr == REG_STATUS) flag_n = 1'b0;
    end
    if (del_slip) begin
      flag_n = 1'b1;
      dir_n  = 1'b1;
    end else if (dup_slip) begin
      flag_n = 1'b1;
      dir_n  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slip_ie   <= 1'b0;
      slip_flag <= 1'b0;
      slip_dir  <= 1'b0;
      reg_rdata <= '0;
    end else begin
      slip_ie   <= ie_n;
      slip_flag <= flag_n;
      slip_dir  <= dir_n;
      reg_rdata <= rdata_n;
    end
  end

  assign irq = slip_flag & slip_ie;
endmodule

// File: rtl/frame_slip_store.sv
`timescale 1ns/1ps
module frame_slip_store #(
  parameter int FRAME_BYTES = 24,
  parameter int NUM_FRAMES  = 2,
  localparam int SW = $clog2(NUM_FRAMES),
  localparam int BW = $clog2(FRAME_BYTES)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic       wr_sof,
  input  logic [7:0] wr_data,
  input  logic       rd_en,
  input  logic       rd_sof,
  output logic [7:0] rd_data,
  input  logic       reg_addr,
  input  logic       reg_wr,
  input  logic       reg_rd,
  input  logic       reg_wdata,
  output logic [1:0] reg_rdata,
  output logic       irq
);
  logic [1:0]    rst_pipe;
  logic          rst_sync_n;
  logic [SW-1:0] fill, rslot, mem_wslot, mem_rslot;
  logic [BW-1:0] mem_wbyte, mem_rbyte;
  logic          mem_we, mem_re, commit, take, del_slip, dup_slip;
  logic          slip_flag, slip_dir, slip_ie;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  esb_occupancy #(.NUM_FRAMES(NUM_FRAMES)) u_occ (
    .clk(clk), .rst_n(rst_sync_n), .commit(commit), .take(take),
    .fill(fill), .rslot(rslot));

  esb_wr_ctrl #(.FRAME_BYTES(FRAME_BYTES), .NUM_FRAMES(NUM_FRAMES)) u_wr (
    .clk(clk), .rst_n(rst_sync_n), .wr_en(wr_en), .wr_sof(wr_sof),
    .fill(fill), .rslot(rslot), .mem_we(mem_we), .mem_wslot(mem_wslot),
    .mem_wbyte(mem_wbyte), .commit(commit), .del_slip(del_slip));

  esb_rd_ctrl #(.FRAME_BYTES(FRAME_BYTES), .NUM_FRAMES(NUM_FRAMES)) u_rd (
    .clk(clk), .rst_n(rst_sync_n), .rd_en(rd_en), .rd_sof(rd_sof),
    .fill(fill), .rslot(rslot), .mem_re(mem_re), .mem_rslot(mem_rslot),
    .mem_rbyte(mem_rbyte), .take(take), .dup_slip(dup_slip));

  esb_store #(.FRAME_BYTES(FRAME_BYTES), .NUM_FRAMES(NUM_FRAMES)) u_mem (
    .clk(clk), .rst_n(rst_sync_n), .we(mem_we), .wslot(mem_wslot),
    .wbyte(mem_wbyte), .wdata(wr_data), .re(mem_re), .rslot(mem_rslot),
    .rbyte(mem_rbyte), .rdata(rd_data));

  esb_status u_stat (
    .clk(clk), .rst_n(rst_sync_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_rd(reg_rd), .reg_wdata(reg_wdata), .del_slip(del_slip),
    .dup_slip(dup_slip), .reg_rdata(reg_rdata), .slip_flag(slip_flag),
    .slip_dir(slip_dir), .slip_ie(slip_ie), .irq(irq));
endmodule

// File: rtl/esb_checker.sv
`timescale 1ns/1ps
module esb_checker #(
  parameter int SW = 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          reg_addr,
  input logic          reg_rd,
  input logic          del_slip,
  input logic          dup_slip,
  input logic          commit,
  input logic          take,
  input logic [SW-1:0] fill,
  input logic          slip_flag,
  input logic          slip_dir,
  input logic          slip_ie,
  input logic          irq
);
  assert_slip_sets_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (del_slip || dup_slip) |=> slip_flag);

  assert_read_clears_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_addr && !del_slip && !dup_slip) |=> !slip_flag);

  assert_dup_direction_R3: assert property (@(posedge clk) disable iff (!rst_n)
    dup_slip |=> !slip_dir);

  assert_del_direction_R4: assert property (@(posedge clk) disable iff (!rst_n)
    del_slip |=> slip_dir);

  assert_irq_on_slip_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((del_slip || dup_slip) && slip_ie) |=> irq);

  assert_slip_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(del_slip && dup_slip));

  assert_commit_fills_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && !take) |=> (fill != '0));
endmodule

bind frame_slip_store esb_checker #(.SW(SW)) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .reg_addr(reg_addr), .reg_rd(reg_rd),
  .del_slip(del_slip), .dup_slip(dup_slip), .commit(commit), .take(take),
  .fill(fill), .slip_flag(slip_flag), .slip_dir(slip_dir),
  .slip_ie(slip_ie), .irq(irq));

// File: tb/test_frame_slip_store.sv
`timescale 1ns/1ps
module test_frame_slip_store;
  localparam int FB = 24;
  localparam real CLK_NS = 8.0;

  logic       clk, rst_n;
  logic       wr_en, wr_sof, rd_en, rd_sof;
  logic [7:0] wr_data, rd_data;
  logic       reg_addr, reg_wr, reg_rd, reg_wdata;
  logic [1:0] reg_rdata;
  logic       irq;
  int checks = 0;
  int errors = 0;

  frame_slip_store #(.FRAME_BYTES(FB), .NUM_FRAMES(2)) i_frame_slip_store (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sof(wr_sof), .wr_data(wr_data),
    .rd_en(rd_en), .rd_sof(rd_sof), .rd_data(rd_data), .reg_addr(reg_addr),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq(irq));

  initial clk = 1'b0;
  always #(CLK_NS / 2.0) clk = ~clk;

  function automatic logic [7:0] pat(input logic [7:0] base, input int i);
    return 8'((int'(base) + i * 7) & 255);
  endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic wr_bytes(input logic [7:0] base, input int n, input bit with_sof);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      wr_en = 1'b1; wr_sof = with_sof && (i == 0); wr_data = pat(base, i);
    end
    @(negedge clk);
    wr_en = 1'b0; wr_sof = 1'b0;
  endtask

  task automatic rd_frame(input logic [7:0] base, input string req);
    int bad = 0;
    logic [7:0] first_act = '0, first_exp = '0;
    for (int i = 0; i <= FB; i++) begin
      @(negedge clk);
      if (i > 0 && rd_data !== pat(base, i - 1)) begin
        if (bad == 0) begin first_act = rd_data; first_exp = pat(base, i - 1); end
        bad++;
      end
      rd_en = (i < FB); rd_sof = (i == 0);
    end
    chk(req, "frame byte", int'(first_act), int'(first_exp));
  endtask

  task automatic reg_write(input logic addr, input logic d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = addr; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic reg_read(input logic addr, output logic [1:0] d);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = addr;
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  task automatic t_reset;
    logic [1:0] d;
    chk("R1", "irq", int'(irq), 0);
    reg_read(1'b0, d); chk("R1", "cfg", int'(d), 0);
    reg_read(1'b1, d); chk("R1", "status", int'(d), 0);
    reg_write(1'b1, 1'b1);
    reg_read(1'b1, d); chk("R11", "status after write", int'(d), 0);
    reg_read(1'b0, d); chk("R11", "cfg after status write", int'(d), 0);
  endtask

  task automatic t_pass;
    logic [1:0] d;
    wr_bytes(8'h10, FB, 1'b1);
    rd_frame(8'h10, "R2");
    reg_read(1'b1, d); chk("R9", "no slip after first frame", int'(d), 0);
  endtask

  task automatic t_dup;
    logic [1:0] d;
    rd_frame(8'h10, "R3");
    reg_read(1'b1, d); chk("R3", "status after duplicate", int'(d), 1);
    reg_read(1'b1, d); chk("R5", "status cleared by read", int'(d), 0);
  endtask

  task automatic t_irq;
    logic [1:0] d;
    reg_write(1'b0, 1'b1);
    reg_read(1'b0, d); chk("R7", "cfg readback", int'(d), 1);
    wr_bytes(8'h40, FB, 1'b1);
    rd_frame(8'h40, "R2");
    chk("R7", "irq idle", int'(irq), 0);
    rd_frame(8'h40, "R3");
    chk("R7", "irq after slip", int'(irq), 1);
    reg_read(1'b1, d); chk("R5", "status", int'(d), 1);
    chk("R7", "irq after clear", int'(irq), 0);
  endtask

  task automatic t_full;
    logic [1:0] d;
    wr_bytes(8'h70, FB, 1'b1);
    wr_bytes(8'hA0, FB, 1'b1);
    chk("R4", "irq after delete", int'(irq), 1);
    rd_frame(8'h70, "R4");
    reg_read(1'b1, d); chk("R4", "status after delete", int'(d), 3);
    rd_frame(8'h70, "R3");
    reg_read(1'b1, d); chk("R8", "direction follows latest", int'(d), 1);
  endtask

  task automatic t_partial;
    logic [1:0] d;
    wr_bytes(8'hC0, 5, 1'b1);
    wr_bytes(8'hD0, FB, 1'b1);
    wr_bytes(8'h33, 3, 1'b0);
    rd_frame(8'hD0, "R10");
    reg_read(1'b1, d); chk("R10", "no slip on restart", int'(d), 0);
  endtask

  task automatic t_race;
    logic [1:0] d;
    @(negedge clk);
    rd_en = 1'b1; rd_sof = 1'b1; reg_rd = 1'b1; reg_addr = 1'b1;
    @(negedge clk);
    rd_en = 1'b0; rd_sof = 1'b0; reg_rd = 1'b0;
    chk("R6", "status before race", int'(reg_rdata), 0);
    chk("R3", "replayed first byte", int'(rd_data), int'(pat(8'hD0, 0)));
    reg_write(1'b0, 1'b0);
    chk("R7", "irq with enable off", int'(irq), 0);
    reg_read(1'b1, d); chk("R6", "flag kept", int'(d), 1);
  endtask

  initial begin
    #(CLK_NS * 200000.0);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_sof = 1'b0; wr_data = '0;
    rd_en = 1'b0; rd_sof = 1'b0; reg_addr = 1'b0; reg_wr = 1'b0;
    reg_rd = 1'b0; reg_wdata = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset;
    t_pass;
    t_dup;
    t_irq;
    t_full;
    t_partial;
    t_race;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule